// File: doc/BRIEF.md
# Per-Processor Interrupt Delivery and Acknowledge Unit

This unit sits between the source side of a prioritized interrupt controller and one processor. It holds two sets of source flags: requests waiting for delivery (raised) and sources the processor has taken but not yet retired (in service). It also holds a 4-bit task priority and drives a registered interrupt line to the processor. Each source supplies its priority, vector, activity and sense (edge or level) on input buses. The unit itself holds none of that per-source state.

The processor talks to the unit through a simple register port with four selects. Reading the acknowledge select returns a vector and moves the winning request into service. Writing the end-of-interrupt select retires the top in-service source. When a source's activity or pending flag must be dropped, the unit pulses one-hot clear outputs back to the source logic.

Top module: `pic_cpu_port`

## Requirements
- R1: After reset the interrupt line is low, both sets are empty and the task priority reads as 0.
- R2: A write to select 0 (task priority) stores bits [3:0] of the write data. A read of select 0 returns that value zero-extended to 32 bits.
- R3: A read of select 1 returns the CPU_ID parameter. A read of select 3 (end of interrupt) returns zero. Writes to selects 1 and 2 change no state.
- R4: A request pulse on source i adds it to the raised set. The interrupt line is set on the next clock when the priority of i is greater than the task priority and either nothing is in service or it is greater than the top in-service priority. A request that fails these tests leaves the line as it was.
- R5: A read of select 2 (acknowledge) clears the interrupt line on the next clock. This takes precedence over every other cause of setting the line.
- R6: An acknowledge with an empty raised set returns the spurious vector in bits [7:0] and zero above, and it pulses no clear output.
- R7: Acknowledge picks the raised source with the highest priority, with ties going to the lowest index. The pick always leaves the raised set. When it is valid, it enters the in-service set and its own vector is returned.
- R8: The pick is stale when its activity is 0 or its priority is not greater than the task priority. A stale pick returns the spurious vector, pulses act_clr_o for it and does not enter service.
- R9: When an edge-sensitive pick (sense 0) is acknowledged, act_clr_o and pend_clr_o pulse for it. A valid level-sensitive pick (sense 1) pulses neither.
- R10: A write to select 3 removes the in-service source with the highest priority, with ties going to the lowest index. When the set is empty it removes nothing.
- R11: After an end-of-interrupt write, the line is high when the raised set is not empty and either nothing remains in service or the top raised priority is greater than the top remaining in-service priority. The task priority plays no part in this test. A request in the same cycle may still set the line as in R4.
- R12: A request on the source that an acknowledge picks in the same cycle is dropped, so that source is not raised afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raise_i | input | NUM_SRC | Per-source request pulses |
| src_prio_i | input | NUM_SRC*4 | Per-source priority, source i at bits [4i+3:4i] |
| src_vec_i | input | NUM_SRC*8 | Per-source vector, source i at bits [8i+7:8i] |
| src_act_i | input | NUM_SRC | Per-source activity flag |
| src_sense_i | input | NUM_SRC | Per-source sense, 1 level, 0 edge |
| spur_vec_i | input | 8 | Spurious vector |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Select: 0 task priority, 1 identity, 2 acknowledge, 3 end of interrupt |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| int_o | output | 1 | Interrupt line to the processor |
| act_clr_o | output | NUM_SRC | One-hot pulse clearing a source's activity |
| pend_clr_o | output | NUM_SRC | One-hot pulse clearing a source's pending flag |

## Verification
A wrong raised or in-service set does not show at the moment it goes wrong. It shows on the interrupt line one clock after a later request or end-of-interrupt write, or as a wrong vector and clear pulse on the next acknowledge. The bench therefore compares int_o on every clock and compares rdata_o and both clear outputs on every cycle against a behavioural model. This catches a corrupted bit within the few operations that consult it. Directed sequences set up priority ties, stale and inactive picks, a same-cycle request and acknowledge, and end-of-interrupt on an empty set. A long random phase then mixes requests, priority changes and bus operations.

// File: rtl/pic_cpu_pkg.sv
package pic_cpu_pkg;
  typedef enum logic [1:0] {
    SEL_TPRI  = 2'd0,
    SEL_IDENT = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_EOI   = 2'd3
  } sel_e;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]    mask_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!valid_o || prio_i[i*PW +: PW] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/pic_cpu_port.sv
module pic_cpu_port
  import pic_cpu_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32,
  parameter int CPU_ID  = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        raise_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_SRC*VEC_W-1:0]  src_vec_i,
  input  logic [NUM_SRC-1:0]        src_act_i,
  input  logic [NUM_SRC-1:0]        src_sense_i,
  input  logic [VEC_W-1:0]          spur_vec_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [1:0]                sel_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      int_o,
  output logic [NUM_SRC-1:0]        act_clr_o,
  output logic [NUM_SRC-1:0]        pend_clr_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] raised_q, inserv_q, raised_d, inserv_d;
  logic [PRIO_W-1:0]  tpr_q;
  logic               int_q, int_d;

  logic              rs_v, sv_v, sa_v;
  logic [IW-1:0]     rs_idx, sv_idx, sa_idx;
  logic [PRIO_W-1:0] rs_prio, sv_prio, sa_prio;
  logic [NUM_SRC-1:0] sv_hot, rs_hot, after_eoi;

  pic_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_pick_raised (
    .mask_i(raised_q), .prio_i(src_prio_i),
    .valid_o(rs_v), .idx_o(rs_idx), .prio_o(rs_prio));

  pic_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_pick_serv (
    .mask_i(inserv_q), .prio_i(src_prio_i),
    .valid_o(sv_v), .idx_o(sv_idx), .prio_o(sv_prio));

  assign sv_hot    = sv_v ? (NUM_SRC'(1) << sv_idx) : '0;
  assign rs_hot    = rs_v ? (NUM_SRC'(1) << rs_idx) : '0;
  assign after_eoi = inserv_q & ~sv_hot;

  pic_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_pick_after (
    .mask_i(after_eoi), .prio_i(src_prio_i),
    .valid_o(sa_v), .idx_o(sa_idx), .prio_o(sa_prio));

  logic ack_rd, eoi_wr, tpr_wr, ack_ok, eoi_cond, raise_hit;
  logic [NUM_SRC-1:0] ack_take;

  assign ack_rd   = rd_i && (sel_e'(sel_i) == SEL_ACK);
  assign eoi_wr   = wr_i && (sel_e'(sel_i) == SEL_EOI);
  assign tpr_wr   = wr_i && (sel_e'(sel_i) == SEL_TPRI);
  assign ack_ok   = rs_v && src_act_i[rs_idx] && (rs_prio > tpr_q);
  assign ack_take = ack_rd ? rs_hot : '0;
  assign eoi_cond = rs_v && (!sa_v || rs_prio > sa_prio);

  always_comb begin
    raise_hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raise_i[i] && !ack_take[i] &&
          src_prio_i[i*PRIO_W +: PRIO_W] > tpr_q &&
          (!sv_v || src_prio_i[i*PRIO_W +: PRIO_W] > sv_prio))
        raise_hit = 1'b1;
    end
  end

  always_comb begin
    act_clr_o  = '0;
    pend_clr_o = '0;
    if (ack_rd && rs_v) begin
      if (!ack_ok || !src_sense_i[rs_idx]) act_clr_o = rs_hot;
      if (!src_sense_i[rs_idx])            pend_clr_o = rs_hot;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_e'(sel_i))
        SEL_TPRI:  rdata_o = DATA_W'(tpr_q);
        SEL_IDENT: rdata_o = DATA_W'(CPU_ID);
        SEL_ACK:   rdata_o = DATA_W'(ack_ok ? src_vec_i[rs_idx*VEC_W +: VEC_W] : spur_vec_i);
        SEL_EOI:   rdata_o = '0;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign raised_d = (raised_q | raise_i) & ~ack_take;
  assign inserv_d = (inserv_q | ((ack_rd && ack_ok) ? rs_hot : '0))
                    & ~(eoi_wr ? sv_hot : '0);

  always_comb begin
    if (ack_rd)      int_d = 1'b0;
    else if (eoi_wr) int_d = eoi_cond | raise_hit;
    else             int_d = int_q | raise_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raised_q <= '0;
      inserv_q <= '0;
      tpr_q    <= '0;
      int_q    <= 1'b0;
    end else begin
      raised_q <= raised_d;
      inserv_q <= inserv_d;
      int_q    <= int_d;
      if (tpr_wr) tpr_q <= wdata_i[PRIO_W-1:0];
    end
  end

  assign int_o = int_q;

  p_ack_drops_int_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |=> !int_o);
  p_tpr_low_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_wr |=> tpr_q == $past(wdata_i[PRIO_W-1:0]));
  p_ack_leaves_raised_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && rs_v) |=> !raised_q[$past(rs_idx)]);
  p_eoi_retires_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && sv_v) |=> !inserv_q[$past(sv_idx)]);
  p_stale_no_service_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && rs_v && !ack_ok && !inserv_q[rs_idx]) |=> !inserv_q[$past(rs_idx)]);
  p_clr_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_clr_o) && ((pend_clr_o & ~act_clr_o) == '0));
endmodule

// File: tb/tb_pic_cpu_port.sv
module tb_pic_cpu_port;
  localparam int N = 8;
  localparam int ID = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] raise = '0, act_v = '0, sense_v = '0;
  logic [3:0] m_prio [N];
  logic [7:0] m_vec [N];
  logic [N*4-1:0] prio_bus;
  logic [N*8-1:0] vec_bus;
  logic [7:0] spur = 8'hFF;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] sel = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic int_w;
  logic [N-1:0] aclr, pclr;

  always_comb for (int i = 0; i < N; i++) begin
    prio_bus[i*4 +: 4] = m_prio[i];
    vec_bus[i*8 +: 8]  = m_vec[i];
  end

  pic_cpu_port #(.NUM_SRC(N), .CPU_ID(ID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .src_prio_i(prio_bus),
    .src_vec_i(vec_bus), .src_act_i(act_v), .src_sense_i(sense_v),
    .spur_vec_i(spur), .rd_i(rd), .wr_i(wr), .sel_i(sel), .wdata_i(wd),
    .rdata_o(rdata), .int_o(int_w), .act_clr_o(aclr), .pend_clr_o(pclr));

  int checks = 0, errors = 0;
  bit m_raised [N];
  bit m_serv [N];
  int m_tpr = 0;
  bit m_int = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int pick(input bit s [N]);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (s[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  task automatic step(input logic [N-1:0] rq, input bit r, input bit w,
                      input logic [1:0] s, input logic [31:0] d, input string tag);
    int rp, sp, ap;
    bit ok, ack, eoi, hit, ec;
    bit after [N];
    logic [31:0] er;
    logic [N-1:0] ea, ep;
    chk({tag, " int"}, 32'(int_w), 32'(m_int));
    raise = rq; rd = r; wr = w; sel = s; wd = d;
    #1;
    ack = r && s == 2'd2;
    eoi = w && s == 2'd3;
    rp = pick(m_raised);
    sp = pick(m_serv);
    after = m_serv;
    if (sp >= 0) after[sp] = 0;
    ap = pick(after);
    ok = rp >= 0 && act_v[rp] && int'(m_prio[rp]) > m_tpr;
    ea = '0; ep = '0;
    if (ack && rp >= 0) begin
      if (!ok || !sense_v[rp]) ea[rp] = 1'b1;
      if (!sense_v[rp]) ep[rp] = 1'b1;
    end
    er = 0;
    if (r) case (s)
      2'd0: er = 32'(m_tpr);
      2'd1: er = ID;
      2'd2: er = ok ? 32'(m_vec[rp]) : 32'(spur);
      default: er = 0;
    endcase
    chk({tag, " rdata"}, rdata, er);
    chk({tag, " act_clr"}, 32'(aclr), 32'(ea));
    chk({tag, " pend_clr"}, 32'(pclr), 32'(ep));
    hit = 0;
    for (int i = 0; i < N; i++)
      if (rq[i] && !(ack && rp == i) && int'(m_prio[i]) > m_tpr &&
          (sp < 0 || m_prio[i] > m_prio[sp])) hit = 1;
    ec = rp >= 0 && (ap < 0 || m_prio[rp] > m_prio[ap]);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (rq[i]) m_raised[i] = 1;
    if (ack && rp >= 0) begin
      m_raised[rp] = 0;
      if (ok) m_serv[rp] = 1;
    end
    if (eoi && sp >= 0) m_serv[sp] = 0;
    if (ack) m_int = 0;
    else if (eoi) m_int = ec | hit;
    else m_int = m_int | hit;
    if (w && s == 2'd0) m_tpr = int'(d[3:0]);
    @(negedge clk);
    raise = '0; rd = 0; wr = 0;
  endtask

  task automatic idle(input string tag); step('0, 0, 0, 0, 0, tag); endtask
  task automatic ack(input string tag); step('0, 1, 0, 2'd2, 0, tag); endtask
  task automatic eoi(input string tag); step('0, 0, 1, 2'd3, 0, tag); endtask
  task automatic rq(input logic [N-1:0] m, input string tag); step(m, 0, 0, 0, 0, tag); endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 4'(i); m_vec[i] = 8'(8'h40 + i);
      m_raised[i] = 0; m_serv[i] = 0;
    end
    act_v = '1;
    sense_v = 8'b1010_1010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step('0, 1, 0, 2'd0, 0, "R1 tpr reset");
    // R2 low bits kept
    step('0, 0, 1, 2'd0, 32'h1234_567A, "R2 tpr write");
    step('0, 1, 0, 2'd0, 0, "R2 tpr read");
    // R3 identity, eoi read, ignored writes
    step('0, 1, 0, 2'd1, 0, "R3 ident");
    step('0, 1, 0, 2'd3, 0, "R3 eoi read");
    step('0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R3 ident write");
    step('0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R3 ack write");
    step('0, 1, 0, 2'd0, 0, "R3 tpr after ignored writes");
    step('0, 0, 1, 2'd0, 32'h2, "R2 tpr=2");
    // R6 empty ack
    ack("R6 empty ack");
    // configure
    m_prio[0] = 5; m_prio[1] = 7; m_prio[2] = 7; m_prio[3] = 1;
    m_prio[4] = 9; m_prio[5] = 3; m_prio[6] = 6; m_prio[7] = 2;
    // R4 / R7 tie
    rq(8'b0000_0110, "R4 raise s1 s2");
    idle("R4 int high");
    ack("R7 tie picks s1");
    idle("R5 int low after ack");
    ack("R7 second pick s2");
    rq(8'b0000_0001, "R4 raise below in-service");
    idle("R4 no int");
    ack("R9 edge pick s0");
    eoi("R10 retire s1");
    idle("R11 int after eoi");
    // R8 stale by priority
    rq(8'b0000_1000, "R8 raise low prio");
    ack("R8 stale prio");
    // R8 inactive
    act_v[5] = 1'b0;
    rq(8'b0010_0000, "R8 raise inactive");
    ack("R8 inactive");
    act_v[5] = 1'b1;
    // R11 reassert
    rq(8'b0001_0000, "R4 raise s4");
    ack("R5 ack s4");
    rq(8'b0100_0000, "R11 raise s6");
    eoi("R11 eoi s4 leaves s2");
    idle("R11 check");
    eoi("R11 eoi s2 leaves s0");
    idle("R11 s6 beats s0");
    // R12 raise with ack same cycle
    step(8'b0100_0000, 1, 0, 2'd2, 0, "R12 raise and ack s6");
    ack("R12 s6 dropped");
    // drain
    repeat (4) eoi("R10 drain");
    eoi("R10 eoi on empty");
    idle("R10 idle");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] m;
      int op;
      if ($urandom_range(0, 7) == 0) begin
        int j = $urandom_range(0, N - 1);
        m_prio[j] = 4'($urandom_range(0, 15));
        act_v[j]  = 1'($urandom_range(0, 3) != 0);
        sense_v[j] = 1'($urandom_range(0, 1));
      end
      m = ($urandom_range(0, 2) == 0) ? N'($urandom) : '0;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: step(m, 1, 0, 2'd2, 0, "R7 rand ack");
        3, 4:    step(m, 0, 1, 2'd3, 0, "R10 rand eoi");
        5:       step(m, 0, 1, 2'd0, $urandom, "R2 rand tpr");
        6:       step(m, 1, 0, 2'($urandom_range(0, 3)), 0, "R3 rand read");
        default: step(m, 0, 0, 0, 0, "R4 rand raise");
      endcase
    end
    idle("R11 final");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule